// File: doc/BRIEF.md
# Cell Insertion OCV Debounce Sequencer

This block forms the first open-circuit-voltage (OCV) estimate whenever the fuel gauge starts over. Such a start follows a reset, a quick-start request from a pin or from a register bit, or a detected battery swap. After each start it watches sixteen cell-voltage samples taken one millisecond apart and keeps the largest one as the OCV estimate. It then flags when the OCV is ready, and later flags when the state-of-charge result would be ready. A small tick counter stands in for the SOC computation latency.

Every restart leaves a one-cycle pulse on `restartPulse` for the rest of the gauge. A battery swap is seen as the cell dropping below a programmable reset level and then coming back above it. Recovery is judged by the fast comparator input when that comparator is enabled, and by the measured samples otherwise. Each path has its own delay before the restart fires.

Top module: `ocv_startup_seq`

## Requirements
- R1: After reset is released, exactly one restart pulse is issued. `ocvReady` and `socReady` stay low and `ocvValue` reads 0.
- R2: After a restart, only the first 16 `msTick` pulses fold a sample into the estimate. On each of them, the most recent sample delivered with `sampleValid` is compared. `ocvValue` is the largest of those 16 samples. Samples seen on later ticks do not change it.
- R3: `ocvReady` rises on the 17th `msTick` after a restart and not before.
- R4: `socReady` rises on the 175th `msTick` after `ocvReady` rose, which is the 192nd tick after the restart, and not before. `socReady` is never high while `ocvReady` is low.
- R5: A rising edge on `qsPin` restarts the sequence once. The pin passes through two synchronizer flops and an edge detector. Holding the pin high gives no further restarts.
- R6: A `qsWrite` strobe sets a pending quick-start bit, visible on `qsPending` in the next cycle. That bit clears itself in the cycle after it is taken as a restart.
- R7: A restart in the middle of a window clears the running maximum and both ready flags. A fresh 16-sample window then begins.
- R8: With `cmpEnable`=1, `cmpLow` going high and then low arms a swap restart. The restart fires on the first `msTick` after recovery.
- R9: With `cmpEnable`=0, the reset level in sample units is `resetThr`×32, so one step is 40 mV at 1.25 mV per sample LSB. A valid sample below that level, followed by a valid sample at or above it, arms a swap restart. The restart fires on the 250th `msTick` after recovery.
- R10: No swap restart happens unless the low condition of the active mode was seen first. With `cmpEnable`=1, low samples are ignored and only `cmpLow` counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| sampleValid | input | 1 | Strobe for a new cell-voltage sample |
| sampleData | input | 12 | Cell-voltage sample, 1.25 mV per LSB |
| qsPin | input | 1 | Asynchronous quick-start pin |
| qsWrite | input | 1 | Strobe for a write of 1 to the quick-start bit |
| cmpLow | input | 1 | Fast comparator: cell is below the reset level |
| cmpEnable | input | 1 | Selects comparator (1) or sample (0) swap detection |
| resetThr | input | 7 | Reset level in 40 mV steps |
| ocvValue | output | 12 | Captured OCV estimate (running maximum) |
| ocvReady | output | 1 | OCV estimate complete |
| socReady | output | 1 | SOC result available |
| restartPulse | output | 1 | One-cycle restart to the rest of the gauge |
| qsPending | output | 1 | Quick-start bit awaiting service |

## Verification
Faults in the millisecond counter appear as `ocvReady` or `socReady` rising one tick early or late. The bench therefore samples these flags right after the 16th, 17th, 191st and 192nd ticks. A maximum register that is not cleared, or that folds one tick too many, shows up on `ocvValue` at the 17th tick. To expose this, windows place the largest sample first or last, and a larger sample is offered on the tick after the window closes. Faults in the swap detector change the tick on which `restartPulse` appears, so its count is checked on the tick before and on the tick of the expected fire.

// File: rtl/ocv_seq_pkg.sv
package ocv_seq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrMax;  // restart: drop the running maximum
    logic fold;    // window tick: fold latest sample into maximum
  } dp_strobe_t;
endpackage

// File: rtl/ocv_seq_dp.sv
module ocv_seq_dp
  import ocv_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  dp_strobe_t          ctl,
  output logic [SAMPLE_W-1:0] ocvValue
);
  logic [SAMPLE_W-1:0] latest;
  logic [SAMPLE_W-1:0] maxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latest <= '0;
      maxReg <= '0;
    end else begin
      if (sampleValid) latest <= sampleData;
      if (ctl.clrMax) maxReg <= '0;
      else if (ctl.fold && (latest > maxReg)) maxReg <= latest;
    end
  end

  assign ocvValue = maxReg;

  // R2
  max_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrMax |=> (maxReg >= $past(maxReg)));
  // R7
  max_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrMax |=> (maxReg == '0));
endmodule

// File: rtl/ocv_seq_swap.sv
module ocv_seq_swap #(
  parameter int SAMPLE_W  = 12,
  parameter int THR_W     = 7,
  parameter int THR_SHIFT = 5,
  parameter int FAST_MS   = 1,
  parameter int SLOW_MS   = 250
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                cmpLow,
  input  logic                cmpEnable,
  input  logic [THR_W-1:0]    resetThr,
  output logic                swapFire
);
  localparam int DLY_MAX = (FAST_MS > SLOW_MS) ? FAST_MS : SLOW_MS;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  logic [SAMPLE_W-1:0] thrLevel;
  logic                lowCond, highCond;
  logic [CNT_W-1:0]    limitM1;
  logic                seen, waiting;
  logic [CNT_W-1:0]    dcnt;

  assign thrLevel = SAMPLE_W'({resetThr, {THR_SHIFT{1'b0}}});
  assign lowCond  = cmpEnable ? cmpLow  : (sampleValid && (sampleData <  thrLevel));
  assign highCond = cmpEnable ? !cmpLow : (sampleValid && (sampleData >= thrLevel));
  assign limitM1  = cmpEnable ? CNT_W'(FAST_MS - 1) : CNT_W'(SLOW_MS - 1);
  assign swapFire = waiting && msTick && !lowCond && (dcnt >= limitM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen    <= 1'b0;
      waiting <= 1'b0;
      dcnt    <= '0;
    end else if (lowCond) begin
      seen    <= 1'b1;
      waiting <= 1'b0;
      dcnt    <= '0;
    end else if (seen && highCond) begin
      seen    <= 1'b0;
      waiting <= 1'b1;
      dcnt    <= '0;
    end else if (waiting && msTick) begin
      if (dcnt >= limitM1) begin
        waiting <= 1'b0;
        dcnt    <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // R10
  arm_needs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> $past(seen));
  // R8
  fire_ends_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapFire |=> !waiting);
endmodule

// File: rtl/ocv_seq_ctrl.sv
module ocv_seq_ctrl
  import ocv_seq_pkg::*;
#(
  parameter int WIN_SAMPLES = 16,
  parameter int OCV_MS      = 17,
  parameter int SOC_MS      = 175
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       qsPin,
  input  logic       qsWrite,
  input  logic       swapFire,
  output dp_strobe_t dpCtl,
  output logic       restartPulse,
  output logic       ocvReady,
  output logic       socReady,
  output logic       qsPending
);
  localparam int SOC_AT = OCV_MS + SOC_MS;
  localparam int CNT_W  = $clog2(SOC_AT + 1);

  logic             startPend;
  logic             qsMeta, qsSync, qsPrev;
  logic             qsRise, restartReq;
  logic [CNT_W-1:0] msCnt;

  assign qsRise     = qsSync && !qsPrev;
  assign restartReq = startPend || qsRise || qsPending || swapFire;

  always_comb begin
    dpCtl.clrMax = restartReq;
    dpCtl.fold   = msTick && !restartReq && (msCnt < CNT_W'(WIN_SAMPLES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPend    <= 1'b1;
      qsMeta       <= 1'b0;
      qsSync       <= 1'b0;
      qsPrev       <= 1'b0;
      qsPending    <= 1'b0;
      restartPulse <= 1'b0;
      msCnt        <= '0;
      ocvReady     <= 1'b0;
      socReady     <= 1'b0;
    end else begin
      startPend    <= 1'b0;
      qsMeta       <= qsPin;
      qsSync       <= qsMeta;
      qsPrev       <= qsSync;
      if (qsWrite) qsPending <= 1'b1;
      else if (qsPending) qsPending <= 1'b0;
      restartPulse <= restartReq;
      if (restartReq) begin
        msCnt    <= '0;
        ocvReady <= 1'b0;
        socReady <= 1'b0;
      end else if (msTick && (msCnt != CNT_W'(SOC_AT))) begin
        msCnt <= msCnt + 1'b1;
        if (msCnt == CNT_W'(OCV_MS - 1)) ocvReady <= 1'b1;
        if (msCnt == CNT_W'(SOC_AT - 1)) socReady <= 1'b1;
      end
    end
  end

  // R4
  soc_after_ocv_chk: assert property (@(posedge clk) disable iff (!rstN)
    socReady |-> ocvReady);
  // R3
  ocv_rise_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocvReady) |-> $past(msTick));
  // R7
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> (!ocvReady && !socReady));
  // R6
  qs_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qsPending && !qsWrite) |=> !qsPending);
endmodule

// File: rtl/ocv_startup_seq.sv
module ocv_startup_seq
  import ocv_seq_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int THR_W       = 7,
  parameter int THR_SHIFT   = 5,
  parameter int WIN_SAMPLES = 16,
  parameter int OCV_MS      = 17,
  parameter int SOC_MS      = 175,
  parameter int FAST_MS     = 1,
  parameter int SLOW_MS     = 250
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                qsPin,
  input  logic                qsWrite,
  input  logic                cmpLow,
  input  logic                cmpEnable,
  input  logic [THR_W-1:0]    resetThr,
  output logic [SAMPLE_W-1:0] ocvValue,
  output logic                ocvReady,
  output logic                socReady,
  output logic                restartPulse,
  output logic                qsPending
);
  dp_strobe_t dpCtl;
  logic       swapFire;

  ocv_seq_swap #(
    .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT),
    .FAST_MS(FAST_MS), .SLOW_MS(SLOW_MS)
  ) uSwap (
    .clk(clk), .rstN(rstN), .msTick(msTick), .sampleValid(sampleValid),
    .sampleData(sampleData), .cmpLow(cmpLow), .cmpEnable(cmpEnable),
    .resetThr(resetThr), .swapFire(swapFire)
  );

  ocv_seq_ctrl #(
    .WIN_SAMPLES(WIN_SAMPLES), .OCV_MS(OCV_MS), .SOC_MS(SOC_MS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .qsPin(qsPin),
    .qsWrite(qsWrite), .swapFire(swapFire), .dpCtl(dpCtl),
    .restartPulse(restartPulse), .ocvReady(ocvReady),
    .socReady(socReady), .qsPending(qsPending)
  );

  ocv_seq_dp #(.SAMPLE_W(SAMPLE_W)) uDp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleData(sampleData), .ctl(dpCtl), .ocvValue(ocvValue)
  );
endmodule

// File: tb/ocv_startup_seq_test.sv
module ocv_startup_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msTick = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        qsPin = 1'b0;
  logic        qsWrite = 1'b0;
  logic        cmpLow = 1'b0;
  logic        cmpEnable = 1'b1;
  logic [6:0]  resetThr = 7'd70;
  logic [11:0] ocvValue;
  logic        ocvReady, socReady, restartPulse, qsPending;

  int checks = 0;
  int failures = 0;
  int restartCnt = 0;

  always #5 clk = ~clk;

  ocv_startup_seq uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .sampleValid(sampleValid),
    .sampleData(sampleData), .qsPin(qsPin), .qsWrite(qsWrite),
    .cmpLow(cmpLow), .cmpEnable(cmpEnable), .resetThr(resetThr),
    .ocvValue(ocvValue), .ocvReady(ocvReady), .socReady(socReady),
    .restartPulse(restartPulse), .qsPending(qsPending)
  );

  always @(negedge clk) if (rstN && restartPulse) restartCnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick(input logic [11:0] v);
    sampleData = v; sampleValid = 1'b1; step();
    sampleValid = 1'b0; msTick = 1'b1; step();
    msTick = 1'b0;
  endtask

  function automatic logic [11:0] bigger(input logic [11:0] a, input logic [11:0] b);
    return (a > b) ? a : b;
  endfunction

  // qsWrite restart: R6
  task automatic qsRestart();
    int base;
    base = restartCnt;
    qsWrite = 1'b1; step(); qsWrite = 1'b0;
    chk("R6 pending set", int'(qsPending), 1);
    step();
    chk("R6 pending self-cleared", int'(qsPending), 0);
    step();
    chk("R6 restart from bit", restartCnt, base + 1);
    chk("R7 ocvReady cleared", int'(ocvReady), 0);
  endtask

  // 16-sample window; kind 0 ascending, 1 max first, 2 random
  task automatic window(input int kind, input string tag);
    logic [11:0] expMax, v;
    expMax = '0;
    for (int i = 0; i < 16; i++) begin
      case (kind)
        0: v = 12'(100 + i * 200);
        1: v = (i == 0) ? 12'd4000 : 12'(i * 50);
        default: v = 12'($urandom % 4000);
      endcase
      expMax = bigger(expMax, v);
      tick(v);
    end
    chk({tag, " R3 ocvReady low after 16 ticks"}, int'(ocvReady), 0);
    tick(12'd4095);
    chk({tag, " R3 ocvReady at 17th tick"}, int'(ocvReady), 1);
    chk({tag, " R2 max of window"}, int'(ocvValue), int'(expMax));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [11:0] expMax, v;
    void'($urandom(32'd2024));
    repeat (3) step();
    rstN = 1'b1;
    repeat (3) step();
    // R1
    chk("R1 one restart after reset", restartCnt, 1);
    chk("R1 ocvReady low", int'(ocvReady), 0);
    chk("R1 socReady low", int'(socReady), 0);
    chk("R1 ocvValue zero", int'(ocvValue), 0);

    // R2 R3 R4 window after reset, with SOC latency
    window(0, "w0");
    base = restartCnt;
    for (int i = 0; i < 174; i++) tick(12'd3000);
    chk("R4 socReady low at tick 191", int'(socReady), 0);
    tick(12'd3000);
    chk("R4 socReady at tick 192", int'(socReady), 1);
    chk("R10 no swap restart without low", restartCnt, base);

    // R6 and max-first window
    qsRestart();
    window(1, "w1");

    // R5 pin edge
    base = restartCnt;
    qsPin = 1'b1;
    repeat (4) step();
    chk("R5 pin edge restart", restartCnt, base + 1);
    repeat (6) step();
    chk("R5 held pin no extra restart", restartCnt, base + 1);
    qsPin = 1'b0;
    repeat (3) step();
    window(2, "w2");

    // random windows
    for (int k = 0; k < 3; k++) begin
      qsRestart();
      window(2, "rnd");
    end

    // R7 restart in mid-window
    qsRestart();
    for (int i = 0; i < 8; i++) tick(12'd4000);
    qsRestart();
    expMax = '0;
    for (int i = 0; i < 16; i++) begin
      v = 12'($urandom % 1000);
      expMax = bigger(expMax, v);
      tick(v);
    end
    chk("R7 ocvReady low before fresh window ends", int'(ocvReady), 0);
    tick(12'd4095);
    chk("R7 ocvReady after fresh window", int'(ocvReady), 1);
    chk("R7 max excludes pre-restart samples", int'(ocvValue), int'(expMax));

    // R10 comparator mode ignores low samples
    cmpEnable = 1'b1;
    base = restartCnt;
    for (int i = 0; i < 260; i++) tick(12'd1000);
    step();
    chk("R10 low samples ignored with comparator", restartCnt, base);

    // R8 fast swap
    cmpLow = 1'b1; step(); cmpLow = 1'b0; repeat (3) step();
    base = restartCnt;
    chk("R8 no restart before tick", restartCnt, base);
    tick(12'd3000); step();
    chk("R8 restart on first tick", restartCnt, base + 1);

    // R9 slow swap, level 70*32 = 2240
    cmpEnable = 1'b0;
    resetThr = 7'd70;
    tick(12'd2000);
    tick(12'd2239);
    base = restartCnt;
    tick(12'd2240);
    for (int i = 0; i < 248; i++) tick(12'd3000);
    step();
    chk("R9 no restart at tick 249", restartCnt, base);
    tick(12'd3000); step();
    chk("R9 restart at tick 250", restartCnt, base + 1);
    chk("R9 ocvReady cleared by swap", int'(ocvReady), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule